// File: doc/BRIEF.md
# Two-Bit-Correcting Byte Memory Codec

This block guards byte-wide memory against radiation upsets with a half-rate linear block code. Each data byte is paired with one check byte, so a stored word is 16 bits. The minimum distance is five, so any one or two flipped bits in a stored word can be repaired, and most heavier damage is flagged.

On the write side the byte goes to the data memory as it is. The check byte is formed in the same cycle, for a second memory that sits beside the first. The check byte is the data byte times an 8x8 matrix over GF(2). That matrix is circulant: every row is the row above it rotated left by one. On the read side the block takes the stored data byte and check byte. It re-encodes the data and XORs the result with the stored check byte to get an 8-bit syndrome. The syndrome depends only on which bits flipped. The syndrome is matched against every pattern of up to two flips. The block returns the repaired byte and a two-bit status. Both paths have one register stage and work at the same time.

Top module: `qc16_codec`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: One cycle after `wr_data` is applied, `wr_parity` equals the XOR of rows r_i over every data bit i that is set. Row r_0 is 8'h17, and r_i is 8'h17 rotated left by i places.
- R3: `wr_data_q` equals `wr_data` from one cycle earlier, with no change.
- R4: The code is quasi-cyclic. The check byte of the data byte rotated left by one place is the earlier check byte rotated left by one place.
- R5: A read word that is a valid codeword gives status 2'b00, and `rd_fixed` equals `rd_data`, one cycle later.
- R6: A read word with one flipped bit in any of its 16 positions gives the original data byte on `rd_fixed` and status 2'b01.
- R7: A read word with any two flipped bits among its 16 positions gives the original data byte and status 2'b10. No syndrome matches more than one pattern of weight one or two.
- R8: A read word with three flipped bits never gives status 2'b00 or 2'b01. Status 2'b11 means no pattern matched, and then `rd_fixed` equals `rd_data` from one cycle earlier, with no bits changed.
- R9: The read path has a latency of one cycle. Its result does not depend on what the write path is doing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 8 | Byte to be stored |
| wr_data_q | output | 8 | Registered byte for the data memory |
| wr_parity | output | 8 | Registered check byte for the parity memory |
| rd_data | input | 8 | Data byte read back from memory |
| rd_parity | input | 8 | Check byte read back from memory |
| rd_fixed | output | 8 | Repaired data byte, registered |
| rd_status | output | 2 | 00 clean, 01 one flip fixed, 10 two flips fixed, 11 not correctable |

## Verification
A wrong row in the circulant matrix, or a bad syndrome comparison, gives the wrong `wr_parity` or `rd_status` on the very next cycle. It shows up only for the data bytes and flip positions that use the faulty term, so the bench tries every data byte with every flip pattern of weight zero, one and two. A locator that matches two patterns for one syndrome, or that changes bits under status 11, shows up in the next cycle as a wrong byte on `rd_fixed`. Random three-flip words find a status that is too low, and they confirm that no bits are changed when the block gives up.

// File: rtl/qc16_pkg.sv
package qc16_pkg;
  localparam int unsigned K_W  = 8;
  localparam int unsigned N_W  = 2 * K_W;
  localparam int unsigned ST_W = 2;
  localparam logic [K_W-1:0] DEF_SEED = 8'h17;

  typedef enum logic [ST_W-1:0] {
    ST_CLEAN = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_FAIL  = 2'b11
  } qc_status_e;

  // Row i of the circulant: seed rotated left by i places.
  function automatic logic [K_W-1:0] circ_row(input logic [K_W-1:0] seed, input int i);
    logic [N_W-1:0] tmp;
    tmp = {seed, seed} << i;
    return tmp[N_W-1:K_W];
  endfunction
endpackage

// File: rtl/qc16_encoder.sv
module qc16_encoder
  import qc16_pkg::*;
#(
  parameter int unsigned    DW   = K_W,
  parameter logic [DW-1:0]  SEED = DEF_SEED
) (
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] check_o
);
  logic [DW-1:0] rows [DW];
  logic [DW-1:0] terms [DW];

  for (genvar i = 0; i < DW; i++) begin : g_row
    assign rows[i]  = circ_row(SEED, i);
    assign terms[i] = data_i[i] ? rows[i] : '0;
  end

  always_comb begin
    check_o = '0;
    for (int i = 0; i < DW; i++) check_o = check_o ^ terms[i];
  end
endmodule

// File: rtl/qc16_locator.sv
module qc16_locator
  import qc16_pkg::*;
#(
  parameter int unsigned    DW   = K_W,
  parameter logic [DW-1:0]  SEED = DEF_SEED
) (
  input  logic [DW-1:0]   syn_i,
  output logic [DW-1:0]   flip_o,
  output logic [ST_W-1:0] status_o
);
  localparam int unsigned NPAIR = DW * (DW - 1) / 2;
  localparam int unsigned NHIT  = 2 + 2 * DW + NPAIR;

  logic [DW-1:0]    rows [DW];
  logic [DW-1:0]    d1p0;      // one data flip, no check flip
  logic [DW-1:0]    d1p1;      // one data flip plus one check flip
  logic [NPAIR-1:0] pair_hit;  // two data flips
  logic [DW-1:0]    pair_flip;
  logic             p1, p2;    // check-byte flips only
  logic             zero;
  logic [NHIT-1:0]  all_hits;

  for (genvar i = 0; i < DW; i++) begin : g_single
    assign rows[i] = circ_row(SEED, i);
    assign d1p0[i] = (syn_i == rows[i]);
    assign d1p1[i] = ($countones(syn_i ^ rows[i]) == 1);
  end

  always_comb begin
    int k;
    k = 0;
    pair_hit  = '0;
    pair_flip = '0;
    for (int i = 0; i < DW; i++) begin
      for (int j = i + 1; j < DW; j++) begin
        if (syn_i == (rows[i] ^ rows[j])) begin
          pair_hit[k]  = 1'b1;
          pair_flip[i] = 1'b1;
          pair_flip[j] = 1'b1;
        end
        k = k + 1;
      end
    end
  end

  assign zero     = (syn_i == '0);
  assign p1       = ($countones(syn_i) == 1);
  assign p2       = ($countones(syn_i) == 2);
  assign all_hits = {p1, p2, d1p0, d1p1, pair_hit};

  always_comb begin
    if (zero)                                 status_o = ST_CLEAN;
    else if (p1 || (|d1p0))                   status_o = ST_ONE;
    else if (p2 || (|d1p1) || (|pair_hit))    status_o = ST_TWO;
    else                                      status_o = ST_FAIL;
  end

  assign flip_o = d1p0 | d1p1 | pair_flip;

  always_comb begin
    AST_ONE_MATCH: assert ($onehot0(all_hits)) else $error("syndrome matched twice"); // R7
  end
endmodule

// File: rtl/qc16_codec.sv
module qc16_codec
  import qc16_pkg::*;
#(
  parameter int unsigned    DW   = K_W,
  parameter logic [DW-1:0]  SEED = DEF_SEED
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   wr_data_q,
  output logic [DW-1:0]   wr_parity,
  input  logic [DW-1:0]   rd_data,
  input  logic [DW-1:0]   rd_parity,
  output logic [DW-1:0]   rd_fixed,
  output logic [ST_W-1:0] rd_status
);
  logic [DW-1:0]   enc_chk;
  logic [DW-1:0]   reenc_chk;
  logic [DW-1:0]   syn;
  logic [DW-1:0]   flip;
  logic [ST_W-1:0] status;

  qc16_encoder #(.DW(DW), .SEED(SEED)) u_wr_enc (
    .data_i (wr_data),
    .check_o(enc_chk)
  );

  qc16_encoder #(.DW(DW), .SEED(SEED)) u_rd_enc (
    .data_i (rd_data),
    .check_o(reenc_chk)
  );

  assign syn = reenc_chk ^ rd_parity;

  qc16_locator #(.DW(DW), .SEED(SEED)) u_loc (
    .syn_i   (syn),
    .flip_o  (flip),
    .status_o(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_data_q <= '0;
      wr_parity <= '0;
      rd_fixed  <= '0;
      rd_status <= '0;
    end else begin
      wr_data_q <= wr_data;
      wr_parity <= enc_chk;
      rd_fixed  <= rd_data ^ flip;
      rd_status <= status;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (wr_data_q == '0 && wr_parity == '0 && rd_fixed == '0 && rd_status == '0)); // R1

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wr_data_q == $past(wr_data))); // R3

  AST_CLEAN_WORD: assert property (@(posedge clk) disable iff (rst)
    (syn == '0) |=> (rd_status == ST_CLEAN && rd_fixed == $past(rd_data))); // R5

  AST_FAIL_RAW: assert property (@(posedge clk) disable iff (rst)
    (rd_status == ST_FAIL) |-> (rd_fixed == $past(rd_data))); // R8

  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (status == ST_ONE) |=> ($countones(rd_fixed ^ $past(rd_data)) <= 1)); // R6
endmodule

// File: tb/sim_qc16_codec.sv
module sim_qc16_codec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_data = '0, rd_data = '0, rd_parity = '0;
  logic [7:0] wr_data_q, wr_parity, rd_fixed;
  logic [1:0] rd_status;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qc16_codec u0 (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_data_q(wr_data_q),
    .wr_parity(wr_parity), .rd_data(rd_data), .rd_parity(rd_parity),
    .rd_fixed(rd_fixed), .rd_status(rd_status)
  );

  // Check bit j is the XOR of d[i] & seed[(j - i) mod 8] over all i.
  function automatic logic [7:0] bpar(input logic [7:0] d);
    logic [7:0] s = 8'h17;
    logic [7:0] p = '0;
    for (int j = 0; j < 8; j++)
      for (int i = 0; i < 8; i++)
        p[j] = p[j] ^ (d[i] & s[(j - i + 8) % 8]);
    return p;
  endfunction

  function automatic logic [7:0] rotl1(input logic [7:0] v);
    return {v[6:0], v[7]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Apply write byte and stored word, then sample one cycle later.
  task automatic cycle(input logic [7:0] wd, input logic [7:0] d, input logic [7:0] p);
    @(negedge clk);
    wr_data = wd; rd_data = d; rd_parity = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      report();
    end
  end

  initial begin
    logic [7:0]  d, p, q;
    logic [15:0] e;
    void'($urandom(32'd20240611));

    // R1: reset clears outputs despite busy inputs
    wr_data = 8'hA5; rd_data = 8'h3C; rd_parity = 8'hF0;
    repeat (3) @(negedge clk);
    chk({wr_data_q, wr_parity, rd_fixed, rd_status} == '0, "R1 reset",
        {6'd0, wr_data_q, wr_parity, rd_fixed, rd_status}, 32'd0);
    @(negedge clk) rst = 1'b0;

    // R4: rotate data left, check byte rotates left
    for (int n = 0; n < 16; n++) begin
      d = (n == 0) ? 8'h01 : 8'($urandom);
      cycle(d, 8'h00, 8'h00); p = wr_parity;
      cycle(rotl1(d), 8'h00, 8'h00); q = wr_parity;
      chk(q == rotl1(p), "R4 quasi-cyclic", {24'd0, q}, {24'd0, rotl1(p)});
    end

    // Exhaustive: every byte, every flip pattern of weight 0, 1, 2 (R2 R3 R5 R6 R7 R9)
    for (int v = 0; v < 256; v++) begin
      d = 8'(v);
      p = bpar(d);
      cycle(~d, d, p);
      chk(wr_parity == bpar(~d), "R2 parity", {24'd0, wr_parity}, {24'd0, bpar(~d)});
      chk(wr_data_q == ~d, "R3 pass", {24'd0, wr_data_q}, {24'd0, ~d});
      chk(rd_fixed == d && rd_status == 2'b00, "R5 clean",
          {22'd0, rd_status, rd_fixed}, {22'd0, 2'b00, d});
      for (int a = 0; a < 16; a++) begin
        e = 16'd1 << a;
        cycle(d, d ^ e[7:0], p ^ e[15:8]);
        chk(rd_fixed == d && rd_status == 2'b01, "R6 single",
            {22'd0, rd_status, rd_fixed}, {22'd0, 2'b01, d});
        for (int b = a + 1; b < 16; b++) begin
          e = (16'd1 << a) | (16'd1 << b);
          cycle(8'($urandom), d ^ e[7:0], p ^ e[15:8]);
          chk(rd_fixed == d && rd_status == 2'b10, "R7 double R9",
              {22'd0, rd_status, rd_fixed}, {22'd0, 2'b10, d});
        end
      end
    end

    // R8: three flips, directed then random
    for (int n = 0; n < 2000; n++) begin
      int a, b, c;
      d = 8'($urandom);
      if (n == 0) begin a = 0; b = 1; c = 2; d = 8'h00; end
      else if (n == 1) begin a = 13; b = 14; c = 15; end
      else begin
        a = $urandom % 16;
        do b = $urandom % 16; while (b == a);
        do c = $urandom % 16; while (c == a || c == b);
      end
      e = (16'd1 << a) | (16'd1 << b) | (16'd1 << c);
      cycle(d, d ^ e[7:0], bpar(d) ^ e[15:8]);
      chk(rd_status[1] == 1'b1, "R8 status", {30'd0, rd_status}, 32'd2);
      if (rd_status == 2'b11)
        chk(rd_fixed == (d ^ e[7:0]), "R8 raw", {24'd0, rd_fixed}, {24'd0, d ^ e[7:0]});
    end

    done = 1'b1;
    report();
  end
endmodule